// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block holds the first sixty-four bytes of a PCI Type 0 configuration header and answers reads and writes arriving over a plain dword-indexed access port (index, byte enables, write strobe, data). Identity fields such as vendor, device, revision, class code, subsystem identifiers and interrupt pin are fixed by parameters. Command, the sticky error part of Status, Cache Line Size, Latency Timer and Interrupt Line are held in registers.

Up to three base address windows live at dwords 4, 5 and 6. Each window is memory or I/O type and spans a power-of-two size between 16 bytes and 2 GB. Software sizes a window by writing all ones and reading back, because address bits below the window size cannot be written. The block also compares an incoming bus address with every active window and raises a per-window hit. A hit needs the matching space enable in Command.

Read data is a pure function of the index and the stored state, so a read has no side effects. A write takes effect at the rising clock edge that samples it.

Top module: `pci_cfg_header`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE[23:0], REV_ID}. Writes to either dword change nothing.
- R2: Dwords 7 to 10, 12, 14 and every index of 16 or above read zero, and writes to them have no effect.
- R3: A window of size 2^k reads its bits k-1..0 as zero except bit 0. Bit 0 reads 1 for I/O type and 0 for memory type. After all ones is written, the window reads ~(2^k-1) with bit 0 set to the type.
- R4: Window slots at or above NUM_BARS read zero, ignore writes and never hit.
- R5: A write updates only the bytes whose enable bit is set. acc_be[n] covers data bits 8n+7..8n.
- R6: In Command (dword 1, bits 15:0) only bits 0, 1, 2, 6, 8 and 10 can be written. All other Command bits read zero.
- R7: Status (dword 1, bits 31:16) has error flags at bits 15, 14, 13, 12, 11 and 8, set by err_event[5], [4], [3], [2], [1] and [0] respectively. Writing 1 clears a flag and writing 0 leaves it. When an event and a clear hit the same flag in one cycle, the event wins. Status bit 4 reads 1 exactly when CAP_PTR is nonzero. All other Status bits read zero.
- R8: Dword 3 reads {8'h00 (self-test), 8'h00 (header type), Latency Timer, Cache Line Size}. Its two low bytes are writable and its upper two bytes read zero. Interrupt Line (dword 15, bits 7:0) is writable.
- R9: Dword 15 bits 31:8 read {MAX_LAT, MIN_GNT, INT_PIN}, dword 13 reads CAP_PTR in bits 7:0, and dword 11 reads {SUBSYS_ID, SUBSYS_VENDOR_ID}. All of these are read-only.
- R10: bar_hit[i] is 1 exactly when window i is active, hit_io equals its type, the matching space enable is set (Command bit 0 for I/O, bit 1 for memory) and hit_addr equals the window base in all bits at or above the window size.
- R11: After reset, Command, the Status error flags, every window base, Latency Timer, Cache Line Size and Interrupt Line are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_idx | input | IDX_W | Dword index into configuration space |
| acc_be | input | 4 | Byte enables for a write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_idx (combinational) |
| err_event | input | 6 | One-cycle pulses that set Status error flags |
| hit_addr | input | 32 | Bus address to decode |
| hit_io | input | 1 | 1 when hit_addr is an I/O access |
| bar_hit | output | 3 | Per-window address match |

## Verification
On every cycle, the assertions check that a hit never appears without the matching space enable, that unimplemented indices read zero, that Command never holds a non-writable bit, and that Status error flags are set by events and only fall after a write to dword 1. Some properties need a model of the stored state and can only be shown by the bench's scenarios: the size probe read-back, byte-enable merging, the event-over-clear priority, read-only identity fields and the exact window comparison. The bench mixes random writes, events and decodes with those directed cases.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
   localparam int unsigned MAX_BARS  = 3;
   localparam int unsigned ERR_BITS  = 6;
   localparam logic [15:0] STAT_CAP  = 16'h0010;

   localparam int unsigned DW_ID     = 0;
   localparam int unsigned DW_CMD    = 1;
   localparam int unsigned DW_CLASS  = 2;
   localparam int unsigned DW_MISC   = 3;
   localparam int unsigned DW_BAR0   = 4;
   localparam int unsigned DW_SUBSYS = 11;
   localparam int unsigned DW_CAP    = 13;
   localparam int unsigned DW_INTR   = 15;

   // error flag vector -> status halfword (flags at 15..11 and 8)
   function automatic logic [15:0] err_to_stat(input logic [ERR_BITS-1:0] e);
      return {e[5:1], 2'b00, e[0], 8'h00};
   endfunction

   function automatic logic [ERR_BITS-1:0] stat_to_err(input logic [15:0] s);
      return {s[15:11], s[8]};
   endfunction
endpackage

// File: rtl/cfg_bar.sv
module cfg_bar #(
   parameter int unsigned SIZE_LOG2 = 12,
   parameter bit          IS_IO     = 1'b0,
   parameter bit          ACTIVE    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  wr_be,
   input  logic [31:0] wr_data,
   input  logic        io_space_en,
   input  logic        mem_space_en,
   input  logic [31:0] probe_addr,
   input  logic        probe_is_io,
   output logic [31:0] rd_data,
   output logic        hit
);
   localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);

   generate
      if (ACTIVE) begin : g_on
         logic [31:0] base_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q <= '0;
            end else if (wr_en) begin
               for (int b = 0; b < 4; b++) begin
                  if (wr_be[b]) base_q[b*8 +: 8] <= wr_data[b*8 +: 8] & ADDR_MASK[b*8 +: 8];
               end
            end
         end

         assign rd_data = base_q | {31'd0, IS_IO};
         assign hit     = (probe_is_io == IS_IO)
                        && (IS_IO ? io_space_en : mem_space_en)
                        && ((probe_addr & ADDR_MASK) == base_q);
      end else begin : g_off
         logic unused_off;
         assign unused_off = &{1'b0, clk, rst_n, wr_en, wr_be, wr_data, io_space_en,
                               mem_space_en, probe_addr, probe_is_io};
         assign rd_data = '0;
         assign hit     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_cmdstat.sv
module cfg_cmdstat
   import pci_cfg_pkg::*;
#(
   parameter logic [15:0] CMD_WMASK   = 16'h0547,
   parameter bit          CAP_PRESENT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_be,
   input  logic [31:0]         wr_data,
   input  logic [ERR_BITS-1:0] err_event,
   output logic [15:0]         cmd,
   output logic [15:0]         status
);
   logic [15:0]         cmd_q;
   logic [ERR_BITS-1:0] err_q, err_clr, err_next;
   logic [15:0]         stat_wr;

   assign stat_wr  = {wr_be[3] ? wr_data[31:24] : 8'h00,
                      wr_be[2] ? wr_data[23:16] : 8'h00};
   assign err_clr  = wr_en ? stat_to_err(stat_wr) : '0;
   // an event in the same cycle as a clear keeps the flag set
   assign err_next = (err_q & ~err_clr) | err_event;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         err_q <= '0;
      end else begin
         if (wr_en) begin
            if (wr_be[0]) cmd_q[7:0]  <= wr_data[7:0]  & CMD_WMASK[7:0];
            if (wr_be[1]) cmd_q[15:8] <= wr_data[15:8] & CMD_WMASK[15:8];
         end
         err_q <= err_next;
      end
   end

   assign cmd    = cmd_q;
   assign status = err_to_stat(err_q) | (CAP_PRESENT ? STAT_CAP : 16'h0000);
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
   import pci_cfg_pkg::*;
#(
   parameter logic [15:0]           VENDOR_ID        = 16'hA5C3,
   parameter logic [15:0]           DEVICE_ID        = 16'h0123,
   parameter logic [7:0]            REV_ID           = 8'h07,
   parameter logic [23:0]           CLASS_CODE       = 24'h118000,
   parameter logic [15:0]           SUBSYS_VENDOR_ID = 16'h5AA5,
   parameter logic [15:0]           SUBSYS_ID        = 16'h0042,
   parameter logic [7:0]            INT_PIN          = 8'h01,
   parameter logic [7:0]            MIN_GNT          = 8'h04,
   parameter logic [7:0]            MAX_LAT          = 8'h10,
   parameter logic [7:0]            CAP_PTR          = 8'h40,
   parameter int unsigned           NUM_BARS         = 2,
   parameter logic [2:0][4:0]       BAR_LOG2         = {5'd16, 5'd8, 5'd12},
   parameter logic [2:0]            BAR_IO           = 3'b010,
   parameter logic [15:0]           CMD_WMASK        = 16'h0547,
   parameter int unsigned           IDX_W            = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_en,
   input  logic                acc_wr,
   input  logic [IDX_W-1:0]    acc_idx,
   input  logic [3:0]          acc_be,
   input  logic [31:0]         acc_wdata,
   output logic [31:0]         acc_rdata,
   input  logic [ERR_BITS-1:0] err_event,
   input  logic [31:0]         hit_addr,
   input  logic                hit_io,
   output logic [MAX_BARS-1:0] bar_hit
);
   // elaboration-time parameter checks
   generate
      if (NUM_BARS < 1 || NUM_BARS > MAX_BARS) begin : g_bad_num
         $error("NUM_BARS must be 1..3");
      end
      if (IDX_W < 5) begin : g_bad_idx
         $error("IDX_W must be at least 5");
      end
      for (genvar c = 0; c < MAX_BARS; c++) begin : g_chk
         if (BAR_LOG2[c] < 5'd4) begin : g_bad_size
            $error("window size below 16 bytes");
         end
      end
   endgenerate

   logic        wr;
   logic [15:0] cmd_w, status_w;
   logic [7:0]  lat_q, cls_q, iline_q;
   logic [31:0] bar_rd [MAX_BARS];

   assign wr = acc_en && acc_wr;

   cfg_cmdstat #(
      .CMD_WMASK   (CMD_WMASK),
      .CAP_PRESENT (CAP_PTR != 8'h00)
   ) u_cmdstat (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr && acc_idx == IDX_W'(DW_CMD)),
      .wr_be     (acc_be),
      .wr_data   (acc_wdata),
      .err_event (err_event),
      .cmd       (cmd_w),
      .status    (status_w)
   );

   generate
      for (genvar i = 0; i < MAX_BARS; i++) begin : g_bar
         cfg_bar #(
            .SIZE_LOG2 (BAR_LOG2[i]),
            .IS_IO     (BAR_IO[i]),
            .ACTIVE    (i < NUM_BARS)
         ) u_bar (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr && acc_idx == IDX_W'(DW_BAR0 + i)),
            .wr_be        (acc_be),
            .wr_data      (acc_wdata),
            .io_space_en  (cmd_w[0]),
            .mem_space_en (cmd_w[1]),
            .probe_addr   (hit_addr),
            .probe_is_io  (hit_io),
            .rd_data      (bar_rd[i]),
            .hit          (bar_hit[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= '0;
         cls_q   <= '0;
         iline_q <= '0;
      end else if (wr) begin
         if (acc_idx == IDX_W'(DW_MISC)) begin
            if (acc_be[0]) cls_q <= acc_wdata[7:0];
            if (acc_be[1]) lat_q <= acc_wdata[15:8];
         end
         if (acc_idx == IDX_W'(DW_INTR) && acc_be[0]) iline_q <= acc_wdata[7:0];
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_idx[IDX_W-1:4] == '0) begin
         case (acc_idx[3:0])
            4'd0:  acc_rdata = {DEVICE_ID, VENDOR_ID};
            4'd1:  acc_rdata = {status_w, cmd_w};
            4'd2:  acc_rdata = {CLASS_CODE, REV_ID};
            4'd3:  acc_rdata = {16'h0000, lat_q, cls_q};
            4'd4:  acc_rdata = bar_rd[0];
            4'd5:  acc_rdata = bar_rd[1];
            4'd6:  acc_rdata = bar_rd[2];
            4'd11: acc_rdata = {SUBSYS_ID, SUBSYS_VENDOR_ID};
            4'd13: acc_rdata = {24'h000000, CAP_PTR};
            4'd15: acc_rdata = {MAX_LAT, MIN_GNT, INT_PIN, iline_q};
            default: acc_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk
   import pci_cfg_pkg::*;
#(
   parameter logic [15:0] CMD_WMASK = 16'h0547,
   parameter int unsigned IDX_W     = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_en,
   input logic                acc_wr,
   input logic [IDX_W-1:0]    acc_idx,
   input logic [3:0]          acc_be,
   input logic [31:0]         acc_rdata,
   input logic [ERR_BITS-1:0] err_event,
   input logic                hit_io,
   input logic [MAX_BARS-1:0] bar_hit,
   input logic [15:0]         cmd,
   input logic [15:0]         status
);
   logic stat_wr;
   assign stat_wr = acc_en && acc_wr && acc_idx == IDX_W'(DW_CMD) && (|acc_be[3:2]);

   // R10: an I/O hit needs I/O space enabled
   p_io_hit_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|bar_hit) && hit_io) |-> cmd[0]);

   // R10: a memory hit needs memory space enabled
   p_mem_hit_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|bar_hit) && !hit_io) |-> cmd[1]);

   // R2: indices at 16 and above read zero
   p_high_idx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_idx >= IDX_W'(16)) |-> (acc_rdata == 32'd0));

   // R6: Command never holds a non-writable bit
   p_cmd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd & ~CMD_WMASK) == 16'h0000));

   // R7: error flags only fall after a write to the Status half
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_to_err($past(status)) & ~stat_to_err(status)) == '0));

   // R7: an event sets its flag on the next cycle, clear or not
   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_event != '0) |=> ((stat_to_err(status) & $past(err_event)) == $past(err_event)));

   // R7: status bits outside flags and capability bit stay zero
   p_stat_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~(err_to_stat('1) | STAT_CAP)) == 16'h0000));
endmodule

bind pci_cfg_header pci_cfg_header_chk #(
   .CMD_WMASK (CMD_WMASK),
   .IDX_W     (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_wr    (acc_wr),
   .acc_idx   (acc_idx),
   .acc_be    (acc_be),
   .acc_rdata (acc_rdata),
   .err_event (err_event),
   .hit_io    (hit_io),
   .bar_hit   (bar_hit),
   .cmd       (cmd_w),
   .status    (status_w)
);

// File: tb/pci_cfg_header_bench.sv
`timescale 1ns/1ps
module pci_cfg_header_bench;
   localparam logic [15:0] VEN = 16'hA5C3, DEV = 16'h0123;
   localparam logic [7:0]  REV = 8'h07;
   localparam logic [23:0] CLS_CODE = 24'h118000;
   localparam logic [15:0] SUBV = 16'h5AA5, SUBS = 16'h0042;
   localparam logic [7:0]  IPIN = 8'h01, MING = 8'h04, MAXL = 8'h10, CAPP = 8'h40;
   localparam int          NB = 2;
   localparam int          LOG2 [3] = '{12, 8, 16};
   localparam logic [2:0]  BIO = 3'b010;
   localparam logic [15:0] CMASK = 16'h0547;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0;
   logic [5:0]  acc_idx = '0;
   logic [3:0]  acc_be = '0;
   logic [31:0] acc_wdata = '0, acc_rdata;
   logic [5:0]  err_event = '0;
   logic [31:0] hit_addr = '0;
   logic        hit_io = 1'b0;
   logic [2:0]  bar_hit;

   always #2.5 clk = ~clk;

   pci_cfg_header u_pci_cfg_header (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_idx(acc_idx),
      .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .err_event(err_event),
      .hit_addr(hit_addr), .hit_io(hit_io), .bar_hit(bar_hit)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [15:0] m_cmd = '0;
   logic [5:0]  m_err = '0;
   logic [31:0] m_bar [3] = '{32'd0, 32'd0, 32'd0};
   logic [7:0]  m_lat = '0, m_cls = '0, m_il = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] bmask(input int i);
      return ~((32'd1 << LOG2[i]) - 32'd1);
   endfunction

   function automatic logic [15:0] m_stat();
      return {m_err[5:1], 2'b00, m_err[0], 3'b000, (CAPP != 8'h00), 4'h0};
   endfunction

   function automatic logic [31:0] exp_rd(input logic [5:0] idx);
      if (idx >= 6'd16) return 32'd0;
      case (idx[3:0])
         4'd0:  return {DEV, VEN};
         4'd1:  return {m_stat(), m_cmd};
         4'd2:  return {CLS_CODE, REV};
         4'd3:  return {16'h0, m_lat, m_cls};
         4'd4, 4'd5, 4'd6: begin
            int i = int'(idx[3:0]) - 4;
            return (i < NB) ? (m_bar[i] | {31'd0, BIO[i]}) : 32'd0;
         end
         4'd11: return {SUBS, SUBV};
         4'd13: return {24'h0, CAPP};
         4'd15: return {MAXL, MING, IPIN, m_il};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [2:0] exp_hit(input logic [31:0] a, input logic io);
      logic [2:0] h = '0;
      for (int i = 0; i < NB; i++)
         h[i] = (io == BIO[i]) && (io ? m_cmd[0] : m_cmd[1]) && ((a & bmask(i)) == m_bar[i]);
      return h;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
      return r;
   endfunction

   task automatic model_upd(input bit wr, input logic [5:0] idx, input logic [3:0] be,
                            input logic [31:0] d, input logic [5:0] evt);
      if (wr) begin
         if (idx == 6'd1) begin
            logic [31:0] s = merge(32'd0, be, d);
            m_cmd = merge({16'h0, m_cmd}, be & 4'b0011, d)[15:0] & CMASK;
            m_err = m_err & ~{s[31:27], s[24]};
         end
         if (idx == 6'd3) begin
            if (be[0]) m_cls = d[7:0];
            if (be[1]) m_lat = d[15:8];
         end
         if (idx >= 6'd4 && idx <= 6'd6 && int'(idx) - 4 < NB)
            m_bar[int'(idx) - 4] = merge(m_bar[int'(idx) - 4], be, d) & bmask(int'(idx) - 4);
         if (idx == 6'd15 && be[0]) m_il = d[7:0];
      end
      m_err = m_err | evt;
   endtask

   task automatic cyc(input bit wr, input logic [5:0] idx, input logic [3:0] be,
                      input logic [31:0] d, input logic [5:0] evt);
      @(negedge clk);
      acc_en = wr; acc_wr = wr; acc_idx = idx; acc_be = be; acc_wdata = d; err_event = evt;
      @(posedge clk);
      model_upd(wr, idx, be, d, evt);
   endtask

   task automatic wr32(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
      cyc(1'b1, idx, be, d, 6'd0);
   endtask

   task automatic rd_chk(input logic [5:0] idx, input string req);
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; err_event = '0; acc_idx = idx;
      #1;
      chk(acc_rdata === exp_rd(idx), req, acc_rdata, exp_rd(idx));
   endtask

   task automatic rd_const(input logic [5:0] idx, input logic [31:0] exp, input string req);
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; err_event = '0; acc_idx = idx;
      #1;
      chk(acc_rdata === exp, req, acc_rdata, exp);
   endtask

   task automatic hit_chk(input logic [31:0] a, input logic io, input string req);
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; err_event = '0; hit_addr = a; hit_io = io;
      #1;
      chk(bar_hit === exp_hit(a, io), req, {29'd0, bar_hit}, {29'd0, exp_hit(a, io)});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (R1 run) actual=%h expected=%h", 32'd0, 32'd1);
         finish_run();
      end
   end

   initial begin
      int unsigned seed = $urandom(32'd2718);
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11 reset state
      rd_const(6'd1, 32'h0010_0000, "R11 cmd/status after reset");
      rd_const(6'd4, 32'h0000_0000, "R11 window0 after reset");
      rd_const(6'd5, 32'h0000_0001, "R11 window1 (I/O) after reset");
      rd_const(6'd3, 32'h0, "R11 dword3 after reset");
      rd_chk(6'd15, "R11 interrupt dword after reset");

      // R1 identity, read-only
      wr32(6'd0, 4'hF, 32'hFFFF_FFFF);
      wr32(6'd2, 4'hF, 32'h0000_0000);
      rd_const(6'd0, {DEV, VEN}, "R1 id dword");
      rd_const(6'd2, {CLS_CODE, REV}, "R1 class dword");

      // R2 unimplemented
      wr32(6'd8, 4'hF, 32'hFFFF_FFFF);
      wr32(6'd40, 4'hF, 32'hFFFF_FFFF);
      rd_const(6'd7, 32'h0, "R2 dword 7");
      rd_const(6'd8, 32'h0, "R2 dword 8 after write");
      rd_const(6'd12, 32'h0, "R2 dword 12");
      rd_const(6'd14, 32'h0, "R2 dword 14");
      rd_const(6'd40, 32'h0, "R2 dword 40 after write");
      rd_const(6'd63, 32'h0, "R2 dword 63");

      // R3 sizing probe, R4 inactive slot
      wr32(6'd4, 4'hF, 32'hFFFF_FFFF);
      wr32(6'd5, 4'hF, 32'hFFFF_FFFF);
      wr32(6'd6, 4'hF, 32'hFFFF_FFFF);
      rd_const(6'd4, 32'hFFFF_F000, "R3 memory window size probe");
      rd_const(6'd5, 32'hFFFF_FF01, "R3 I/O window size probe");
      rd_const(6'd6, 32'h0, "R4 inactive slot reads zero");

      // R5 byte enables
      wr32(6'd4, 4'b0100, 32'h1234_5678);
      rd_const(6'd4, 32'hFF34_F000, "R5 single byte lane");
      wr32(6'd3, 4'b0010, 32'hAAAA_BBCC);
      rd_const(6'd3, 32'h0000_BB00, "R5 latency byte only");

      // R6 command mask
      wr32(6'd1, 4'b0011, 32'h0000_FFFF);
      rd_const(6'd1, 32'h0010_0547, "R6 command writable bits");

      // R7 status flags
      cyc(1'b0, 6'd0, 4'h0, 32'h0, 6'b111111);
      rd_const(6'd1, 32'hF910_0547, "R7 all events set");
      wr32(6'd1, 4'b1100, 32'h0000_0000);
      rd_const(6'd1, 32'hF910_0547, "R7 write zero keeps flags");
      wr32(6'd1, 4'b1000, 32'h0800_0000);
      rd_const(6'd1, 32'hF110_0547, "R7 clear bit 11");
      cyc(1'b1, 6'd1, 4'b1100, 32'h0100_0000, 6'b000001);
      rd_const(6'd1, 32'hF110_0547, "R7 event beats clear");
      wr32(6'd1, 4'b1100, 32'hFFFF_0000);
      rd_const(6'd1, 32'h0010_0547, "R7 clear all, cap bit stays");

      // R8 misc registers
      wr32(6'd3, 4'hF, 32'hFFFF_2010);
      rd_const(6'd3, 32'h0000_2010, "R8 latency/cache line");
      wr32(6'd15, 4'hF, 32'hFFFF_FF5A);
      rd_const(6'd15, {MAXL, MING, IPIN, 8'h5A}, "R8 interrupt line, R9 fixed bytes");

      // R9 fixed fields
      rd_const(6'd13, {24'h0, CAPP}, "R9 capability pointer");
      rd_const(6'd11, {SUBS, SUBV}, "R9 subsystem ids");

      // R10 decode
      wr32(6'd4, 4'hF, 32'h8000_0000);
      wr32(6'd5, 4'hF, 32'h0000_C000);
      wr32(6'd1, 4'b0011, 32'h0000_0002);
      hit_chk(32'h8000_0ABC, 1'b0, "R10 memory hit");
      hit_chk(32'h8000_0ABC, 1'b1, "R10 type mismatch");
      hit_chk(32'h8000_1000, 1'b0, "R10 just past window");
      hit_chk(32'h0000_C0FF, 1'b1, "R10 I/O disabled");
      wr32(6'd1, 4'b0011, 32'h0000_0001);
      hit_chk(32'h8000_0000, 1'b0, "R10 memory disabled");
      hit_chk(32'h0000_C0FF, 1'b1, "R10 I/O hit");
      wr32(6'd1, 4'b0011, 32'h0000_0003);
      hit_chk(32'h0000_0000, 1'b0, "R4 inactive slot never hits");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [5:0]  idx = 6'($urandom_range(0, 20));
         logic [31:0] d   = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
         logic [5:0]  ev  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd0;
         int          wb  = $urandom_range(0, NB - 1);
         cyc(1'b1, idx, 4'($urandom), d, ev);
         rd_chk(6'($urandom_range(0, 20)), "R5 random readback");
         if ($urandom_range(0, 1) == 0)
            hit_chk(m_bar[wb] | ($urandom & ~bmask(wb)), BIO[wb], "R10 random in-window");
         else
            hit_chk($urandom, 1'($urandom), "R10 random address");
      end

      finish_run();
   end
endmodule